// File: doc/BRIEF.md
# Carry and Overflow Flag Integer Add/Subtract Unit

This block performs five integer arithmetic operations on two words of width W (32 by default). One status bit, called T here, serves as the carry input for add-with-carry, the borrow input for subtract-with-borrow and negate-with-borrow, and the status result of every operation. Each operation has its own rule for the next value of T. Multi-word addition and subtraction can be chained through T, and signed overflow can be tested with T as well.

The arithmetic core is purely combinational. It takes the operands, an operation code and the current T, and returns the result and the next T. A thin registered wrapper holds T between operations. It loads the next T only in cycles where the enable input is high, and it clears T on an active-low asynchronous reset. The result and the next T are visible at the ports in the same cycle that the operands and the code are applied. The operands come from `a_i` and `b_i`, and the negate operation reads `a_i`.

Top module: `flagalu`

## Requirements
- R1: Code 0 (add with carry) gives res_o = a_i + b_i + T modulo 2^W. t_next_o is 1 when either the a_i+b_i stage or the +T stage carries out of bit W-1.
- R2: Code 1 (add, overflow test) gives res_o = a_i + b_i modulo 2^W. t_next_o is 1 only when a_i and b_i have equal sign bits and the sign bit of res_o differs from them.
- R3: Code 2 (subtract with borrow) gives res_o = b_i - a_i - T modulo 2^W. t_next_o is 1 when either the b_i-a_i stage or the -T stage borrows.
- R4: Code 3 (subtract, overflow test) gives res_o = b_i - a_i modulo 2^W. t_next_o is 1 only when the sign bits of a_i and b_i differ and the sign bit of res_o differs from that of b_i.
- R5: Code 4 (negate with borrow) gives res_o = 0 - a_i - T modulo 2^W. t_next_o is 1 when 0 - a_i is nonzero or when subtracting T borrows.
- R6: Codes 5, 6 and 7 give res_o = b_i and t_next_o = t_o.
- R7: On a rising clock edge with en_i high, t_o takes the value of t_next_o. With en_i low, t_o keeps its value.
- R8: While rst_ni is low, t_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Loads the next T into the T register |
| op_i | input | 3 | Operation code |
| a_i | input | W | Operand a (subtrahend, negate source) |
| b_i | input | W | Operand b (minuend) |
| res_o | output | W | Combinational result |
| t_next_o | output | 1 | Next value of T |
| t_o | output | 1 | Registered T |

## Verification
The stimulus mixes random words with 0, 1, the largest positive value, the most negative value and all ones. These values exercise several faults. One is a carry produced by the T stage alone, as in all ones + 0 + 1, which a design that keeps only the first-stage carry would lose. Another is a borrow that appears only when b equals a and T is 1. A third is overflow at the sign boundary; a design that swaps the minuend and subtrahend roles would set T on the wrong inputs there. Negating zero must leave T unchanged, and negating any other value must set T. A reference model built from wide signed and unsigned arithmetic predicts every result and every flag. Enable-low cycles show whether T is held or leaks through, and unused codes must pass b through unchanged.

// File: rtl/flagalu_pkg.sv
package flagalu_pkg;
  typedef enum logic [2:0] {
    OP_ADDC = 3'd0,
    OP_ADDV = 3'd1,
    OP_SUBC = 3'd2,
    OP_SUBV = 3'd3,
    OP_NEGC = 3'd4
  } op_e;
endpackage

// File: rtl/flagalu_adder.sv
module flagalu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int WX = W + 1;
  logic [WX-1:0] full;
  assign full   = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
endmodule

// File: rtl/flagalu_core.sv
module flagalu_core
  import flagalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  input  logic         t_i,
  output logic [W-1:0] res_o,
  output logic         t_o
);
  localparam int MSB = W - 1;

  logic         is_add, is_sub, is_neg;
  logic [W-1:0] x1, y1, s1, y2, s2;
  logic         c1, cin1, c2, cin2;

  always_comb begin
    is_add = (op_i == OP_ADDC) || (op_i == OP_ADDV);
    is_sub = (op_i == OP_SUBC) || (op_i == OP_SUBV);
    is_neg = (op_i == OP_NEGC);
  end

  // stage 1: a+b, b+~a+1 (b-a), or 0+~a+1 (-a)
  always_comb begin
    x1   = is_neg ? '0 : (is_sub ? b_i : a_i);
    y1   = is_add ? b_i : ~a_i;
    cin1 = ~is_add;
  end

  flagalu_adder #(.W(W)) u_stage1 (
    .x_i(x1), .y_i(y1), .cin_i(cin1), .sum_o(s1), .cout_o(c1)
  );

  // stage 2: +T, or -T as s1 + all-ones + ~T
  always_comb begin
    y2   = is_add ? '0 : '1;
    cin2 = is_add ? t_i : ~t_i;
  end

  flagalu_adder #(.W(W)) u_stage2 (
    .x_i(s1), .y_i(y2), .cin_i(cin2), .sum_o(s2), .cout_o(c2)
  );

  always_comb begin
    res_o = b_i;
    t_o   = t_i;
    unique case (op_i)
      OP_ADDC: begin
        res_o = s2;
        t_o   = c1 | c2;
      end
      OP_ADDV: begin
        res_o = s1;
        t_o   = (a_i[MSB] == b_i[MSB]) && (s1[MSB] != a_i[MSB]);
      end
      OP_SUBC, OP_NEGC: begin
        res_o = s2;
        t_o   = ~c1 | ~c2;
      end
      OP_SUBV: begin
        res_o = s1;
        t_o   = (a_i[MSB] != b_i[MSB]) && (s1[MSB] != b_i[MSB]);
      end
      default: begin
        res_o = b_i;
        t_o   = t_i;
      end
    endcase
  end
endmodule

// File: rtl/flagalu.sv
module flagalu #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         t_next_o,
  output logic         t_o
);
  logic t_q;

  flagalu_core #(.W(W)) u_core (
    .a_i(a_i), .b_i(b_i), .op_i(op_i), .t_i(t_q),
    .res_o(res_o), .t_o(t_next_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   t_q <= 1'b0;
    else if (en_i) t_q <= t_next_o;
  end

  assign t_o = t_q;
endmodule

// File: rtl/flagalu_chk.sv
module flagalu_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] res_o,
  input logic         t_next_o,
  input logic         t_o
);
  localparam int MSB = W - 1;

  // wrapped sum implies a carry
  a_r1_wrap_sets_t: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0 && res_o < a_i) |-> t_next_o);

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && a_i[MSB] != b_i[MSB]) |-> !t_next_o);

  a_r3_borrow_sets_t: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 && a_i > b_i) |-> t_next_o);

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd3 && a_i[MSB] == b_i[MSB]) |-> !t_next_o);

  a_r5_neg_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4 && a_i != '0) |-> t_next_o);

  a_r6_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 3'd4) |-> (res_o == b_i && t_next_o == t_o));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(t_o));

  a_r7_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (t_o == $past(t_next_o)));
endmodule

bind flagalu flagalu_chk #(.W(W)) u_chk (.*);

// File: tb/flagalu_tb.sv
module flagalu_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [2:0]   op = 3'd0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] res;
  logic         t_next, t_reg;

  int checks = 0;
  int fails  = 0;
  bit model_t = 1'b0;

  always #4 clk = ~clk;

  flagalu #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .op_i(op),
    .a_i(a), .b_i(b), .res_o(res), .t_next_o(t_next), .t_o(t_reg)
  );

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic void model(input logic [2:0] o, input logic [31:0] x,
                                input logic [31:0] y, input bit t,
                                output logic [31:0] r, output bit tn);
    logic [32:0]    u;
    longint signed  s;
    case (o)
      3'd0: begin u = {1'b0, x} + {1'b0, y} + 33'(t); r = u[31:0]; tn = u[32]; end
      3'd1: begin
        s = longint'($signed(x)) + longint'($signed(y));
        r = x + y; tn = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      3'd2: begin u = {1'b0, y} - {1'b0, x} - 33'(t); r = u[31:0]; tn = u[32]; end
      3'd3: begin
        s = longint'($signed(y)) - longint'($signed(x));
        r = y - x; tn = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      3'd4: begin u = 33'd0 - {1'b0, x} - 33'(t); r = u[31:0]; tn = u[32]; end
      default: begin r = y; tn = t; end
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [31:0] x,
                     input logic [31:0] y, input bit e);
    logic [31:0] er;
    bit          et;
    @(negedge clk);
    op = o; a = x; b = y; en = e;
    #1;
    model(o, x, y, model_t, er, et);
    check(tag(o), res, er);
    check(tag(o), 32'(t_next), 32'(et));
    @(posedge clk);
    #1;
    if (e) model_t = et;
    check("R7", 32'(t_reg), 32'(model_t));
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 10)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 check("R8", 32'(t_reg), 32'd0);
    @(negedge clk) rst_n = 1'b1;

    // R1: carry only from +T stage
    run(3'd4, 32'h5, 32'h0, 1'b1);          // sets T
    run(3'd0, 32'hFFFF_FFFF, 32'h0, 1'b1);
    run(3'd0, 32'h7FFF_FFFF, 32'h1, 1'b1);
    // R2: overflow at sign boundary
    run(3'd1, 32'h7FFF_FFFF, 32'h1, 1'b1);
    run(3'd1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
    // R3: borrow only from -T stage
    run(3'd4, 32'h1, 32'h0, 1'b1);
    run(3'd2, 32'h1234, 32'h1234, 1'b1);
    run(3'd2, 32'h1, 32'h0, 1'b1);
    // R4: swapped roles
    run(3'd3, 32'h1, 32'h8000_0000, 1'b1);
    run(3'd3, 32'h8000_0000, 32'h0, 1'b1);
    // R5: negate zero keeps T
    run(3'd4, 32'h0, 32'h0, 1'b1);
    run(3'd4, 32'h0, 32'h0, 1'b1);
    run(3'd4, 32'h8000_0000, 32'h0, 1'b1);
    // R6: unused codes
    run(3'd5, 32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b1);
    run(3'd7, 32'h0, 32'h1, 1'b1);
    // R7: hold with enable low
    run(3'd4, 32'h3, 32'h0, 1'b1);
    run(3'd1, 32'h0, 32'h0, 1'b0);
    run(3'd2, 32'h0, 32'h0, 1'b0);

    for (int i = 0; i < 3000; i++)
      run(3'($urandom % 8), pick(), pick(), ($urandom % 4) != 0);

    // R8: asynchronous reset clears T
    run(3'd4, 32'h9, 32'h0, 1'b1);
    @(negedge clk) rst_n = 1'b0;
    #1 check("R8", 32'(t_reg), 32'd0);
    model_t = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule